// File: doc/BRIEF.md
# Burst Bus Cycle Sequencer

This block is the master-side sequencer for one external bus access of one to four data words. The core side hands it a request: a start address, a read or write flag, a word count, a wait-state count, three per-access status bits (data rather than instruction fetch, DMA-initiated, supervisor privilege), a flag for a pipelined memory region, and the write data. The block then runs the access on the external bus. It produces a one-clock address strobe, a data-enable strobe, a transceiver direction line and a last-transfer flag. It also counts the programmed wait states in front of every data word.

The slave ends each data word with either a ready input or a burst-terminate input. The block steps the word address after each word it accepts and collects read data. One clock after the final word it returns a done pulse to the core, together with the collected read words. The status outputs follow the same timing as the write/read line. Each is loaded when the block takes a request and held until the next request is taken.

Data enable stays active from one pipelined read into a directly following pipelined read. If the next request is a write, the block inserts one quiet turnaround clock. This keeps the direction line from moving while data enable is active.

Top module: `burst_bus_seq`

## Requirements
- R1: `ads_n_o` is low for exactly one clock per access. It goes low in the first clock after the request is taken, or after the turnaround clock when there is one. `addr_o`, `wr_o`, `dc_o`, `dma_o` and `sup_o` carry the request's values in that clock.
- R2: The wait counter is reloaded from `req_waits_i` before every data word. Each word spends that many clocks with data enable active before `ready_n_i` and `bterm_n_i` are sampled. During those wait clocks both inputs are ignored.
- R3: `blast_n_o` is low only during the final word, and only once its wait count has run out. It stays low for as long as neither `ready_n_i` nor `bterm_n_i` is low, and it goes high in the clock after the word is accepted.
- R4: `den_n_o` goes low in the first data clock and stays low through every data clock of the access. It goes high after the last word, unless R7 keeps it low.
- R5: While `den_n_o` is low for an access, `dtr_o` is 1 for a read (the master receives) and 0 for a write (the master sends).
- R6: `dtr_o` changes only at a clock edge where `den_n_o` is high both before and after that edge.
- R7: A read to a pipelined region (`req_pipe_i`=1), taken in the clock right after a pipelined read finished, keeps `den_n_o` low without a break. Any other request following a pipelined read raises `den_n_o` first. A write in that position gets one extra clock before its address strobe, in which `dtr_o` turns around.
- R8: `wr_o` (1 = write), `dc_o` (1 = data, 0 = instruction), `dma_o` and `sup_o` change only when a request is taken, and they hold stable through the whole access.
- R9: `addr_o` starts at `req_addr_i` and rises by 4 after each accepted word that is not the last one. During a write, `wdata_o` carries word k of `req_wdata_i` (bits k*32 upward) while word k is on the bus.
- R10: A low `bterm_n_i` accepts the current word exactly as a low `ready_n_i` does.
- R11: `done_o` pulses high for one clock, in the clock after the last word is accepted. For a read, `rdata_o` then holds word k of the access in bits k*32 upward.
- R12: `req_valid_i` is ignored while an access is in progress. The block takes a request only when idle. `req_words_i` holds the word count minus one.
- R13: During and straight after reset, `ads_n_o`, `blast_n_o` and `den_n_o` are high, and `dtr_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present (taken only when idle) |
| req_addr_i | input | AW | Start word address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_words_i | input | CW | Word count minus one |
| req_waits_i | input | WAITW | Wait states before each word |
| req_data_i | input | 1 | 1 = data access, 0 = instruction fetch |
| req_dma_i | input | 1 | Access issued by the DMA engine |
| req_sup_i | input | 1 | Access carries supervisor privilege |
| req_pipe_i | input | 1 | Target region is pipelined |
| req_wdata_i | input | NW*DW | Write words, word k in bits k*DW upward |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | NW*DW | Collected read words |
| ads_n_o | output | 1 | Address strobe, active low |
| addr_o | output | AW | Current word address |
| wr_o | output | 1 | Write/read line |
| dc_o | output | 1 | Data-or-code status |
| dma_o | output | 1 | DMA status |
| sup_o | output | 1 | Supervisor status |
| blast_n_o | output | 1 | Last-transfer flag, active low |
| den_n_o | output | 1 | Data enable, active low |
| dtr_o | output | 1 | Transceiver direction, 1 = receive |
| wdata_o | output | DW | Write data for the current word |
| rdata_i | input | DW | Read data from the bus |
| ready_n_i | input | 1 | Slave ready, active low |
| bterm_n_i | input | 1 | Burst terminate, active low |

## Verification
The hardest situation to reach is the moment one access hands over to the next. Data enable has to stay low across a pipelined-read boundary, or break, with a turnaround clock for a write. That only happens when the new request is already present in the single idle clock that carries the done pulse. The stimulus therefore watches the bench's own model and presents the next request during the final word of the running access. It builds chains of pipelined read, pipelined read, write, read and non-pipelined read this way. It also keeps junk requests asserted during the earlier words, to show they are ignored. Slave responses alternate between immediate ready, randomly delayed ready, terminate only, and ready held low through long wait counts.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TURN = 2'd1,
        ST_ADDR = 2'd2,
        ST_DATA = 2'd3
    } bbs_state_e;

    typedef struct packed {
        bbs_state_e state;
        logic       ads_n;
        logic       den_n;
        logic       dtr;
        logic       hold;
        logic       done;
        logic       wr;
        logic       dc;
        logic       dma;
        logic       sup;
        logic       pipe;
    } bbs_ctrl_t;

    localparam bbs_ctrl_t BBS_CTRL_RST = '{
        state: ST_IDLE,
        ads_n: 1'b1,
        den_n: 1'b1,
        dtr:   1'b0,
        hold:  1'b0,
        done:  1'b0,
        wr:    1'b0,
        dc:    1'b0,
        dma:   1'b0,
        sup:   1'b0,
        pipe:  1'b0
    };

endpackage

// File: rtl/bbs_wait_timer.sv
module bbs_wait_timer #(
    parameter int WAITW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [WAITW-1:0] arm_val_i,
    input  logic             reload_i,
    input  logic             run_i,
    output logic             zero_o
);

    typedef struct packed {
        logic [WAITW-1:0] reload;
        logic [WAITW-1:0] cnt;
    } timer_t;

    timer_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (arm_i) begin
            tmr_d.reload = arm_val_i;
        end
        if (reload_i) begin
            tmr_d.cnt = tmr_q.reload;
        end else if (run_i && (tmr_q.cnt != '0)) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign zero_o = (tmr_q.cnt == '0);

    // R2: a reload followed by running always gives a full count from the stored value
    assert_reload_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (zero_o == ($past(tmr_q.reload) == '0)));

endmodule

// File: rtl/bbs_beat_track.sv
module bbs_beat_track #(
    parameter int AW   = 32,
    parameter int CW   = 2,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] words_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o,
    output logic [CW-1:0] idx_o,
    output logic          last_o
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] idx;
        logic [CW-1:0] words;
    } beat_t;

    beat_t beat_d, beat_q;

    always_comb begin
        beat_d = beat_q;
        if (start_i) begin
            beat_d.addr  = base_i;
            beat_d.idx   = '0;
            beat_d.words = words_i;
        end else if (step_i) begin
            beat_d.addr = beat_q.addr + AW'(STEP);
            beat_d.idx  = beat_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign addr_o = beat_q.addr;
    assign idx_o  = beat_q.idx;
    assign last_o = (beat_q.idx == beat_q.words);

    // R9: each step moves the address by one word
    assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !start_i) |=> (addr_o == $past(addr_o) + AW'(STEP)));

    // R9: stepping past the final word never happens
    assert_no_step_past_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> !last_o);

endmodule

// File: rtl/bbs_word_store.sv
module bbs_word_store #(
    parameter int DW = 32,
    parameter int NW = 4,
    parameter int CW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [NW*DW-1:0] load_data_i,
    input  logic             cap_i,
    input  logic [CW-1:0]    cap_idx_i,
    input  logic [DW-1:0]    cap_data_i,
    input  logic [CW-1:0]    sel_idx_i,
    output logic [DW-1:0]    sel_data_o,
    output logic [NW*DW-1:0] all_o
);

    logic [NW*DW-1:0] words_flat;

    for (genvar g = 0; g < NW; g++) begin : g_word
        logic [DW-1:0] w_d, w_q;

        always_comb begin
            w_d = w_q;
            if (load_i) begin
                w_d = load_data_i[g*DW +: DW];
            end else if (cap_i && (cap_idx_i == CW'(g))) begin
                w_d = cap_data_i;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                w_q <= '0;
            end else begin
                w_q <= w_d;
            end
        end

        assign words_flat[g*DW +: DW] = w_q;

        // R11: a captured read word lands in its own slot
        assert_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_i && !load_i && (cap_idx_i == CW'(g))) |=> (w_q == $past(cap_data_i)));
    end

    assign sel_data_o = words_flat[int'(sel_idx_i)*DW +: DW];
    assign all_o      = words_flat;

endmodule

// File: rtl/burst_bus_seq.sv
module burst_bus_seq
    import bbs_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int NW    = 4,
    parameter int WAITW = 4,
    parameter int CW    = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [AW-1:0]    req_addr_i,
    input  logic             req_write_i,
    input  logic [CW-1:0]    req_words_i,
    input  logic [WAITW-1:0] req_waits_i,
    input  logic             req_data_i,
    input  logic             req_dma_i,
    input  logic             req_sup_i,
    input  logic             req_pipe_i,
    input  logic [NW*DW-1:0] req_wdata_i,
    output logic             done_o,
    output logic [NW*DW-1:0] rdata_o,
    output logic             ads_n_o,
    output logic [AW-1:0]    addr_o,
    output logic             wr_o,
    output logic             dc_o,
    output logic             dma_o,
    output logic             sup_o,
    output logic             blast_n_o,
    output logic             den_n_o,
    output logic             dtr_o,
    output logic [DW-1:0]    wdata_o,
    input  logic [DW-1:0]    rdata_i,
    input  logic             ready_n_i,
    input  logic             bterm_n_i
);

    localparam int STEP = DW / 8;

    bbs_ctrl_t ctrl_d, ctrl_q;

    logic          start;
    logic          accept;
    logic          step;
    logic          reload;
    logic          run;
    logic          cap;
    logic          cnt_zero;
    logic          beat_last;
    logic [CW-1:0] beat_idx;

    assign run    = (ctrl_q.state == ST_DATA);
    assign accept = run && cnt_zero && (!ready_n_i || !bterm_n_i);
    assign step   = accept && !beat_last;
    assign reload = (ctrl_q.state == ST_ADDR) || step;
    assign cap    = accept && !ctrl_q.wr;

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.done  = 1'b0;
        ctrl_d.ads_n = 1'b1;
        start        = 1'b0;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (req_valid_i) begin
                    start       = 1'b1;
                    ctrl_d.wr   = req_write_i;
                    ctrl_d.dc   = req_data_i;
                    ctrl_d.dma  = req_dma_i;
                    ctrl_d.sup  = req_sup_i;
                    ctrl_d.pipe = req_pipe_i;
                    ctrl_d.hold = 1'b0;
                    if (ctrl_q.hold && !req_write_i && req_pipe_i) begin
                        ctrl_d.state = ST_ADDR;
                        ctrl_d.ads_n = 1'b0;
                    end else if (ctrl_q.hold && !req_write_i) begin
                        ctrl_d.state = ST_ADDR;
                        ctrl_d.ads_n = 1'b0;
                        ctrl_d.den_n = 1'b1;
                    end else if (ctrl_q.hold) begin
                        ctrl_d.state = ST_TURN;
                        ctrl_d.den_n = 1'b1;
                    end else begin
                        ctrl_d.state = ST_ADDR;
                        ctrl_d.ads_n = 1'b0;
                        ctrl_d.dtr   = !req_write_i;
                    end
                end else begin
                    ctrl_d.hold  = 1'b0;
                    ctrl_d.den_n = 1'b1;
                end
            end
            ST_TURN: begin
                ctrl_d.state = ST_ADDR;
                ctrl_d.ads_n = 1'b0;
                ctrl_d.dtr   = !ctrl_q.wr;
            end
            ST_ADDR: begin
                ctrl_d.state = ST_DATA;
                ctrl_d.den_n = 1'b0;
            end
            ST_DATA: begin
                if (accept && beat_last) begin
                    ctrl_d.state = ST_IDLE;
                    ctrl_d.done  = 1'b1;
                    ctrl_d.hold  = !ctrl_q.wr && ctrl_q.pipe;
                    ctrl_d.den_n = !(!ctrl_q.wr && ctrl_q.pipe);
                end
            end
            default: begin
                ctrl_d = BBS_CTRL_RST;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= BBS_CTRL_RST;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    bbs_wait_timer #(
        .WAITW (WAITW)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (start),
        .arm_val_i (req_waits_i),
        .reload_i  (reload),
        .run_i     (run),
        .zero_o    (cnt_zero)
    );

    bbs_beat_track #(
        .AW   (AW),
        .CW   (CW),
        .STEP (STEP)
    ) beat_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .base_i  (req_addr_i),
        .words_i (req_words_i),
        .step_i  (step),
        .addr_o  (addr_o),
        .idx_o   (beat_idx),
        .last_o  (beat_last)
    );

    bbs_word_store #(
        .DW (DW),
        .NW (NW),
        .CW (CW)
    ) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (start && req_write_i),
        .load_data_i (req_wdata_i),
        .cap_i       (cap),
        .cap_idx_i   (beat_idx),
        .cap_data_i  (rdata_i),
        .sel_idx_i   (beat_idx),
        .sel_data_o  (wdata_o),
        .all_o       (rdata_o)
    );

    assign ads_n_o   = ctrl_q.ads_n;
    assign den_n_o   = ctrl_q.den_n;
    assign dtr_o     = ctrl_q.dtr;
    assign done_o    = ctrl_q.done;
    assign wr_o      = ctrl_q.wr;
    assign dc_o      = ctrl_q.dc;
    assign dma_o     = ctrl_q.dma;
    assign sup_o     = ctrl_q.sup;
    assign blast_n_o = !(run && beat_last && cnt_zero);

    // R1: the address strobe never lasts two clocks
    assert_ads_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n_o |=> ads_n_o);

    // R2: no word moves on while the wait count is still running
    assert_no_early_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_zero) |=> $stable(beat_idx));

    // R3: the last-transfer flag holds until the slave ends the word
    assert_blast_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!blast_n_o && ready_n_i && bterm_n_i) |=> !blast_n_o);

    // R3: once the final word is taken the flag is released
    assert_blast_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!blast_n_o && (!ready_n_i || !bterm_n_i)) |=> blast_n_o);

    // R4: every data clock has data enable active
    assert_den_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !den_n_o);

    // R5: direction matches the transfer while data flows
    assert_dir_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (dtr_o == !wr_o));

    // R6: direction only moves with data enable inactive on both sides
    assert_dir_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dtr_o != $past(dtr_o)) |-> ($past(den_n_o) && den_n_o));

    // R8: status lines are frozen for the whole access
    assert_status_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state != ST_IDLE) |=> $stable({wr_o, dc_o, dma_o, sup_o}));

    // R11: completion is a single-clock pulse
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/burst_bus_seq_tb_top.sv
`timescale 1ns/1ps
module burst_bus_seq_tb_top;

    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int NW    = 4;
    localparam int WAITW = 4;
    localparam int CW    = 2;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic             req_valid = 1'b0;
    logic [AW-1:0]    req_addr  = '0;
    logic             req_write = 1'b0;
    logic [CW-1:0]    req_words = '0;
    logic [WAITW-1:0] req_waits = '0;
    logic             req_data  = 1'b0;
    logic             req_dma   = 1'b0;
    logic             req_sup   = 1'b0;
    logic             req_pipe  = 1'b0;
    logic [NW*DW-1:0] req_wdata = '0;
    logic [DW-1:0]    rdata_in  = '0;
    logic             ready_n   = 1'b1;
    logic             bterm_n   = 1'b1;

    logic             done;
    logic [NW*DW-1:0] rdata_out;
    logic             ads_n, wr, dc, dma, sup, blast_n, den_n, dtr;
    logic [AW-1:0]    addr;
    logic [DW-1:0]    wdata;

    burst_bus_seq #(
        .AW (AW), .DW (DW), .NW (NW), .WAITW (WAITW), .CW (CW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid_i (req_valid), .req_addr_i (req_addr), .req_write_i (req_write),
        .req_words_i (req_words), .req_waits_i (req_waits), .req_data_i (req_data),
        .req_dma_i (req_dma), .req_sup_i (req_sup), .req_pipe_i (req_pipe),
        .req_wdata_i (req_wdata),
        .done_o (done), .rdata_o (rdata_out),
        .ads_n_o (ads_n), .addr_o (addr), .wr_o (wr), .dc_o (dc), .dma_o (dma),
        .sup_o (sup), .blast_n_o (blast_n), .den_n_o (den_n), .dtr_o (dtr),
        .wdata_o (wdata), .rdata_i (rdata_in), .ready_n_i (ready_n), .bterm_n_i (bterm_n)
    );

    int    n_vec = 0;
    int    n_fail = 0;
    int    cyc = 0;
    int    slave_mode = 0;
    bit    finished = 1'b0;
    string sect = "R13 reset";

    // behavioural reference state
    int            m_phase, m_cnt, m_idx, m_n, m_waits, m_acc;
    logic [AW-1:0] m_addr;
    bit            m_wr, m_dc, m_dma, m_sup, m_pipe, m_hold, m_den, m_dtr, m_done;
    logic [DW-1:0] m_rbuf [NW];
    logic [DW-1:0] m_wbuf [NW];

    initial m_acc = 0;

    task automatic chk(input string sig, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL [%s] %s actual=%0h expected=%0h t=%0t", sect, sig, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    // reference model: phases 0 idle, 1 turnaround, 2 address, 3 data
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_idx = 0; m_n = 1; m_waits = 0;
            m_addr = '0; m_wr = 0; m_dc = 0; m_dma = 0; m_sup = 0; m_pipe = 0;
            m_hold = 0; m_den = 1; m_dtr = 0; m_done = 0;
        end else begin
            m_done = 0;
            case (m_phase)
                0: begin
                    if (req_valid) begin
                        m_acc++;
                        m_addr = req_addr; m_wr = req_write; m_dc = req_data;
                        m_dma = req_dma; m_sup = req_sup; m_pipe = req_pipe;
                        m_n = int'(req_words) + 1; m_waits = int'(req_waits); m_idx = 0;
                        if (req_write)
                            for (int i = 0; i < NW; i++) m_wbuf[i] = req_wdata[i*DW +: DW];
                        if (m_hold && !req_write && req_pipe) begin
                            m_phase = 2;
                        end else if (m_hold && !req_write) begin
                            m_phase = 2; m_den = 1;
                        end else if (m_hold) begin
                            m_phase = 1; m_den = 1;
                        end else begin
                            m_phase = 2; m_dtr = !req_write;
                        end
                        m_hold = 0;
                    end else begin
                        m_hold = 0; m_den = 1;
                    end
                end
                1: begin
                    m_phase = 2; m_dtr = !m_wr;
                end
                2: begin
                    m_phase = 3; m_den = 0; m_cnt = m_waits;
                end
                default: begin
                    if (m_cnt > 0) begin
                        m_cnt--;
                    end else if (!ready_n || !bterm_n) begin
                        if (!m_wr) m_rbuf[m_idx] = rdata_in;
                        if (m_idx == m_n - 1) begin
                            m_phase = 0; m_done = 1;
                            m_hold = !m_wr && m_pipe;
                            m_den = !m_hold;
                        end else begin
                            m_idx++; m_addr = m_addr + 4; m_cnt = m_waits;
                        end
                    end
                end
            endcase
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 ads_n", ads_n, (m_phase == 2) ? 1'b0 : 1'b1);
            chk("R3 blast_n", blast_n, (m_phase == 3 && m_idx == m_n - 1 && m_cnt == 0) ? 1'b0 : 1'b1);
            chk("R4 R7 den_n", den_n, m_den);
            chk("R5 R6 dtr", dtr, m_dtr);
            chk("R9 addr", addr, m_addr);
            chk("R8 status", {wr, dc, dma, sup}, {m_wr, m_dc, m_dma, m_sup});
            chk("R11 done", done, m_done);
            if (m_phase == 3 && m_wr) chk("R9 wdata", wdata, m_wbuf[m_idx]);
            if (m_done && !m_wr)
                for (int i = 0; i < m_n; i++) chk("R11 rdata", rdata_out[i*DW +: DW], m_rbuf[i]);
        end
    end

    // slave responses
    always @(negedge clk) begin
        rdata_in <= $urandom;
        case (slave_mode)
            0: begin ready_n <= 1'b0; bterm_n <= 1'b1; end
            1: begin ready_n <= ($urandom_range(0, 2) != 0); bterm_n <= 1'b1; end
            2: begin ready_n <= 1'b1; bterm_n <= $urandom_range(0, 1) == 1; end
            default: begin ready_n <= 1'b0; bterm_n <= 1'b0; end
        endcase
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_fail++;
            $display("FAIL [%s] R11 watchdog actual=running expected=done", sect);
            finish_run();
        end
    end

    task automatic junk_req(input bit v);
        req_valid = v;
        req_addr  = $urandom;
        req_write = $urandom_range(0, 1) == 1;
        req_words = CW'($urandom_range(0, NW - 1));
        req_waits = WAITW'($urandom_range(0, 3));
        req_data  = $urandom_range(0, 1) == 1;
        req_dma   = $urandom_range(0, 1) == 1;
        req_sup   = $urandom_range(0, 1) == 1;
        req_pipe  = $urandom_range(0, 1) == 1;
    endtask

    task automatic issue(input logic [AW-1:0] a, input bit w, input int n, input int ws,
                         input bit d, input bit dm, input bit s, input bit p, input bit b2b);
        bit go;
        bit last_pending;
        int acc0;
        go = 1'b0;
        while (!go) begin
            @(negedge clk);
            last_pending = (m_phase == 3) && (m_idx == m_n - 1);
            go = (m_phase == 0) || (b2b && last_pending);
            // R12: junk requests while busy must be ignored
            if (!go) junk_req((m_phase != 0) && !last_pending);
        end
        if (!b2b) begin
            req_valid = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
        req_addr  = a;
        req_write = w;
        req_words = CW'(n - 1);
        req_waits = WAITW'(ws);
        req_data  = d;
        req_dma   = dm;
        req_sup   = s;
        req_pipe  = p;
        for (int i = 0; i < NW; i++) req_wdata[i*DW +: DW] = $urandom;
        acc0 = m_acc;
        req_valid = 1'b1;
        while (m_acc == acc0) @(negedge clk);
    endtask

    task automatic drain();
        req_valid = 1'b0;
        while (m_phase != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R13 reset ads_n", ads_n, 1'b1);
        chk("R13 reset blast_n", blast_n, 1'b1);
        chk("R13 reset den_n", den_n, 1'b1);
        chk("R13 reset dtr", dtr, 1'b0);
        chk("R13 reset done", done, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        sect = "R1 R5 single read and write";
        slave_mode = 0;
        issue(32'h0000_1000, 0, 1, 0, 1, 0, 1, 0, 0);
        issue(32'h0000_2000, 1, 1, 0, 0, 1, 0, 0, 0);
        drain();

        sect = "R2 wait states ignore ready";
        slave_mode = 3;
        issue(32'h0000_3000, 0, 2, 5, 1, 0, 0, 0, 0);
        issue(32'h0000_4000, 1, 1, 15, 1, 1, 1, 0, 0);
        drain();

        sect = "R3 last-transfer hold under delayed ready";
        slave_mode = 1;
        issue(32'h0000_5000, 0, 4, 1, 1, 0, 0, 0, 0);
        issue(32'h0000_6000, 1, 3, 0, 0, 0, 1, 0, 0);
        drain();

        sect = "R10 burst terminate accepts words";
        slave_mode = 2;
        issue(32'h0000_7000, 0, 3, 2, 1, 1, 0, 0, 0);
        issue(32'h0000_8000, 1, 4, 0, 1, 0, 0, 0, 0);
        drain();

        sect = "R7 R6 pipelined read chains";
        slave_mode = 0;
        issue(32'h0001_0000, 0, 2, 0, 1, 0, 0, 1, 0);
        issue(32'h0001_0100, 0, 4, 1, 1, 0, 0, 1, 1);
        issue(32'h0001_0200, 1, 2, 0, 1, 0, 0, 0, 1);
        issue(32'h0001_0300, 0, 1, 0, 0, 0, 1, 1, 1);
        issue(32'h0001_0400, 0, 3, 0, 1, 0, 1, 1, 1);
        issue(32'h0001_0500, 0, 2, 2, 1, 0, 0, 0, 1);
        drain();

        sect = "R12 R8 R9 R11 mixed traffic with busy requests";
        for (int k = 0; k < 40; k++) begin
            slave_mode = $urandom_range(0, 2);
            issue($urandom, $urandom_range(0, 1) == 1, $urandom_range(1, NW), $urandom_range(0, 6),
                  $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                  $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                  $urandom_range(0, 1) == 1);
        end
        drain();

        finish_run();
    end

endmodule